// File: doc/BRIEF.md
# CAM Control-State Register File

This block holds the control-side state of a content-addressable memory. It takes one 12-bit instruction per cycle, qualified by a valid flag and a direction strobe. It moves 32-bit words between the data bus and these registers: configuration, comparand, device select, status and seven mask registers. It also moves words between the comparand and a 256-entry storage array, at the location held in an address register. Each storage entry carries an empty flag.

Any write or move may name one of the mask registers. The update then changes only the bit positions where that mask holds 0. Selector value 0 means no mask. One opcode serves both directions: a low strobe loads the register and a high strobe reads it out.

The data bus is modelled as a separate input and output, plus a drive-enable output. Read data is registered and appears one cycle after the read instruction.

Top module: `cam_ctrl_regfile`

## Requirements
- R1: After a synchronous active-low reset, the following all read 0: configuration, comparand, device select, every mask register and the address register. Every storage entry is empty, and `bus_oe` is low.
- R2: The operation is decoded from `instr[5:0]` and the mask selector from `instr[8:6]`. The bits `instr[11:9]` have no effect on the result.
- R3: Operation codes are: 000101 comparand, 000110 configuration, 001000 device select, 001001 mask register, 000111 status (read only), 001100 comparand/storage move. With `wr_n` low and selector 0, the configuration, comparand or device select register loads all 32 bits of `bus_in`.
- R4: With `wr_n` low and selector n in 1..7, a configuration, comparand or device select write updates only the bits where mask n is 0. All other bits keep their value.
- R5: A mask write with selector n in 1..7 loads mask n with the full word. A mask write with selector 0 changes no mask register.
- R6: With `wr_n` high, a defined opcode drives the addressed register on `bus_out`, with `bus_oe` high, in the cycle after the instruction. A mask read with selector 0 returns an unspecified value. The status word holds the address register in bits [15:8] and the empty flag of the addressed entry in bit 0 (1 = empty); all other bits are 0.
- R7: A move with `wr_n` low writes the comparand into the entry at the address register, masked by the selected mask. The entry's empty flag is set from `vld_in_n` (0 = valid, 1 = empty).
- R8: A move with `wr_n` high copies the addressed entry into the comparand, masked by the selected mask. No empty flag changes.
- R9: When `addr_ld` is high, the address register loads `bus_in[7:0]`. An instruction in the same cycle uses the old address.
- R10: An instruction with an undefined opcode, or a status opcode with `wr_n` low, changes no state and does not drive the bus.
- R11: `bus_oe` is high only in the cycle that follows a read of a defined opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_vld | input | 1 | Instruction present this cycle |
| instr | input | 12 | Instruction word |
| wr_n | input | 1 | Direction strobe: low writes, high reads |
| addr_ld | input | 1 | Load the address register from the bus |
| vld_in_n | input | 1 | Empty flag for a move into storage (low = valid) |
| bus_in | input | 32 | Data bus, inbound |
| bus_out | output | 32 | Data bus, outbound (registered) |
| bus_oe | output | 1 | Drive enable for `bus_out` |

## Verification
All register and storage updates take effect at the clock edge that captures the instruction. A read issued afterwards therefore sees the new value. Read data and `bus_oe` become valid one edge after the read is captured. When the driver issues a read, it queues the expected word tagged with the cycle number at which it is due. The monitor samples on the falling edge and pops an item only when its due cycle arrives. In every other cycle it expects `bus_oe` to be low, which is how reads of undefined opcodes and stray drives are caught.

// File: rtl/cam_ctrl_pkg.sv
// Shared widths, opcodes, decoded-command type and masked-merge helper
// for the CAM control-state register file.
package cam_ctrl_pkg;

    localparam int CAM_DW   = 32;
    localparam int CAM_OPW  = 6;
    localparam int CAM_SELW = 3;

    typedef enum logic [CAM_OPW-1:0] {
        OP_CMP  = 6'b000101,
        OP_CFG  = 6'b000110,
        OP_STAT = 6'b000111,
        OP_DSEL = 6'b001000,
        OP_MASK = 6'b001001,
        OP_MOVE = 6'b001100
    } cam_op_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_CFG,
        SRC_CMP,
        SRC_STAT,
        SRC_DSEL,
        SRC_MASK
    } cam_src_e;

    typedef struct packed {
        logic                cfg_we;
        logic                cmp_we;
        logic                dsel_we;
        logic                mask_op_w;
        logic                store_en;
        logic                fetch_en;
        logic                rd_en;
        cam_src_e            rd_src;
        logic [CAM_SELW-1:0] sel;
    } cam_cmd_t;

    // New bits land where keep is 0; positions where keep is 1 hold old.
    function automatic logic [CAM_DW-1:0] cam_merge(
        input logic [CAM_DW-1:0] old_w,
        input logic [CAM_DW-1:0] new_w,
        input logic [CAM_DW-1:0] keep
    );
        return (new_w & ~keep) | (old_w & keep);
    endfunction

endpackage

// File: rtl/cam_instr_decode.sv
// Instruction decoder.
// Turns one instruction word plus the direction strobe into a set of
// one-hot-ish command strobes. Purely combinational. The top INSTR_W-9
// bits are ignored. Undefined opcodes, and a status opcode with the
// strobe low, yield an all-idle command.
module cam_instr_decode
    import cam_ctrl_pkg::*;
#(
    parameter int INSTR_W = 12
) (
    input  logic               vld,
    input  logic [INSTR_W-1:0] instr,
    input  logic               wr_n,
    output cam_cmd_t           cmd
);

    localparam int SEL_LSB = CAM_OPW;

    logic [CAM_OPW-1:0] op;
    assign op = instr[CAM_OPW-1:0];

    // Decode opcode and direction into command strobes.
    always_comb begin
        cmd        = '0;
        cmd.rd_src = SRC_NONE;
        cmd.sel    = instr[SEL_LSB +: CAM_SELW];
        if (vld) begin
            case (op)
                OP_CMP: begin
                    if (wr_n) begin cmd.rd_en = 1'b1; cmd.rd_src = SRC_CMP; end
                    else            cmd.cmp_we = 1'b1;
                end
                OP_CFG: begin
                    if (wr_n) begin cmd.rd_en = 1'b1; cmd.rd_src = SRC_CFG; end
                    else            cmd.cfg_we = 1'b1;
                end
                OP_DSEL: begin
                    if (wr_n) begin cmd.rd_en = 1'b1; cmd.rd_src = SRC_DSEL; end
                    else            cmd.dsel_we = 1'b1;
                end
                OP_MASK: begin
                    if (wr_n) begin cmd.rd_en = 1'b1; cmd.rd_src = SRC_MASK; end
                    else            cmd.mask_op_w = 1'b1;
                end
                OP_STAT: begin
                    if (wr_n) begin cmd.rd_en = 1'b1; cmd.rd_src = SRC_STAT; end
                end
                OP_MOVE: begin
                    if (wr_n) cmd.fetch_en = 1'b1;
                    else      cmd.store_en = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cam_mask_bank.sv
// Mask register bank.
// Holds 2**SEL_W-1 mask registers, numbered 1 up. Selector 0 names no
// register: writes with it are dropped, and the read port returns 0,
// so that a masked merge with selector 0 updates every bit.
module cam_mask_bank #(
    parameter int DW    = 32,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_op,
    input  logic [SEL_W-1:0] sel,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    keep
);

    localparam int NREG = (1 << SEL_W);

    logic [DW-1:0] mask_q [NREG];

    assign mask_q[0] = '0;

    generate
        for (genvar gi = 1; gi < NREG; gi++) begin : g_mask
            // Load mask gi when a mask write selects it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mask_q[gi] <= '0;
                else if (wr_op && (sel == SEL_W'(gi)))
                    mask_q[gi] <= wdata;
            end

            AST_MASK_SEL0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_op && (sel == '0)) |=> $stable(mask_q[gi])); // R5
        end
    endgenerate

    // Select the mask that governs this cycle's update or read.
    always_comb begin
        keep = mask_q[sel];
    end

endmodule

// File: rtl/cam_entry_store.sv
// Entry store.
// A 2**AW x DW array with one empty flag per entry. Entries are written
// as a masked merge of the source word into the current contents. The
// word at the given address and its flag are read asynchronously. Only
// the flags are reset (to empty), not the array contents.
module cam_entry_store #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          st_en,
    input  logic [DW-1:0] st_data,
    input  logic [DW-1:0] keep,
    input  logic          empty_in,
    output logic [DW-1:0] rd_word,
    output logic          rd_empty
);

    localparam int DEPTH = (1 << AW);

    logic [DW-1:0]    mem_q [DEPTH];
    logic [DEPTH-1:0] empty_q;

    // Masked write of the source word into the addressed entry.
    always_ff @(posedge clk) begin
        if (st_en)
            mem_q[addr] <= (st_data & ~keep) | (mem_q[addr] & keep);
    end

    // Track the empty flag of each entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            empty_q <= '1;
        else if (st_en)
            empty_q[addr] <= empty_in;
    end

    assign rd_word  = mem_q[addr];
    assign rd_empty = empty_q[addr];

    AST_FLAG_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |=> (empty_q[$past(addr)] == $past(empty_in))); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_en |=> $stable(empty_q)); // R8

endmodule

// File: rtl/cam_ctrl_regfile.sv
// CAM control-state register file, top level.
// Decodes one instruction per cycle. It updates the configuration,
// comparand and device-select registers with masked merges, drives the
// mask bank and the entry store, and returns one registered read word.
// Assumes a single-driver bus: bus_out is meaningful only when bus_oe
// is high.
module cam_ctrl_regfile
    import cam_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int INSTR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_vld,
    input  logic [INSTR_W-1:0] instr,
    input  logic               wr_n,
    input  logic               addr_ld,
    input  logic               vld_in_n,
    input  logic [CAM_DW-1:0]  bus_in,
    output logic [CAM_DW-1:0]  bus_out,
    output logic               bus_oe
);

    localparam int STAT_ADDR_LSB = 8;

    cam_cmd_t          cmd;
    logic [CAM_DW-1:0] keep;
    logic [CAM_DW-1:0] cfg_q, cmp_q, dsel_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CAM_DW-1:0] ent_word;
    logic              ent_empty;
    logic [CAM_DW-1:0] stat_w;
    logic [CAM_DW-1:0] rd_mux;

    cam_instr_decode #(.INSTR_W(INSTR_W)) u_dec (
        .vld   (instr_vld),
        .instr (instr),
        .wr_n  (wr_n),
        .cmd   (cmd)
    );

    cam_mask_bank #(.DW(CAM_DW), .SEL_W(CAM_SELW)) u_masks (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_op (cmd.mask_op_w),
        .sel   (cmd.sel),
        .wdata (bus_in),
        .keep  (keep)
    );

    cam_entry_store #(.DW(CAM_DW), .AW(ADDR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr_q),
        .st_en    (cmd.store_en),
        .st_data  (cmp_q),
        .keep     (keep),
        .empty_in (vld_in_n),
        .rd_word  (ent_word),
        .rd_empty (ent_empty)
    );

    // Load the address register on an address cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (addr_ld) addr_q <= bus_in[ADDR_W-1:0];
    end

    // Masked update of the configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)          cfg_q <= '0;
        else if (cmd.cfg_we) cfg_q <= cam_merge(cfg_q, bus_in, keep);
    end

    // Masked update of the device-select register.
    always_ff @(posedge clk) begin
        if (!rst_n)           dsel_q <= '0;
        else if (cmd.dsel_we) dsel_q <= cam_merge(dsel_q, bus_in, keep);
    end

    // Masked update of the comparand from the bus or from the store.
    always_ff @(posedge clk) begin
        if (!rst_n)            cmp_q <= '0;
        else if (cmd.cmp_we)   cmp_q <= cam_merge(cmp_q, bus_in, keep);
        else if (cmd.fetch_en) cmp_q <= cam_merge(cmp_q, ent_word, keep);
    end

    // Assemble the status word from address and entry flag.
    always_comb begin
        stat_w = '0;
        stat_w[0] = ent_empty;
        stat_w[STAT_ADDR_LSB +: ADDR_W] = addr_q;
    end

    // Select the register addressed by a read.
    always_comb begin
        case (cmd.rd_src)
            SRC_CFG:  rd_mux = cfg_q;
            SRC_CMP:  rd_mux = cmp_q;
            SRC_STAT: rd_mux = stat_w;
            SRC_DSEL: rd_mux = dsel_q;
            SRC_MASK: rd_mux = keep;
            default:  rd_mux = '0;
        endcase
    end

    // Register read data and bus drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_out <= '0;
            bus_oe  <= 1'b0;
        end else begin
            bus_oe <= cmd.rd_en;
            if (cmd.rd_en) bus_out <= rd_mux;
        end
    end

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_vld |=> !bus_oe); // R11
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && !wr_n) |=> !bus_oe); // R11
    AST_CMP_KEEP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.cmp_we |=> ((cmp_q & $past(keep)) == ($past(cmp_q) & $past(keep)))); // R4
    AST_CFG_KEEP_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.cfg_we |=> ((cfg_q & $past(keep)) == ($past(cfg_q) & $past(keep)))); // R4
    AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && !(instr[CAM_OPW-1:0] inside {OP_CMP, OP_CFG, OP_STAT, OP_DSEL, OP_MASK, OP_MOVE}))
        |=> ($stable(cfg_q) && $stable(cmp_q) && $stable(dsel_q) && !bus_oe)); // R10

endmodule

// File: tb/cam_ctrl_regfile_tb.sv
// Scoreboard bench: driver tasks apply instructions on the falling edge,
// update a reference model and queue expected read words with a due
// cycle; a monitor pops and compares them on the falling edge.
module cam_ctrl_regfile_tb_top;

    localparam logic [5:0] C_CMP  = 6'b000101;
    localparam logic [5:0] C_CFG  = 6'b000110;
    localparam logic [5:0] C_STAT = 6'b000111;
    localparam logic [5:0] C_DSEL = 6'b001000;
    localparam logic [5:0] C_MASK = 6'b001001;
    localparam logic [5:0] C_MOVE = 6'b001100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_vld = 1'b0;
    logic [11:0] instr = '0;
    logic        wr_n = 1'b1;
    logic        addr_ld = 1'b0;
    logic        vld_in_n = 1'b1;
    logic [31:0] bus_in = '0;
    logic [31:0] bus_out;
    logic        bus_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          due;
        logic [31:0] val;
        bit          chk;
        string       req;
    } sb_item_t;
    sb_item_t sb[$];
    sb_item_t cur;

    // Reference model
    logic [31:0] m_cfg, m_cmp, m_dsel;
    logic [31:0] m_mask [8];
    logic [31:0] m_mem  [256];
    logic [255:0] m_empty;
    logic [7:0]  m_addr;

    cam_ctrl_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr),
        .wr_n(wr_n), .addr_ld(addr_ld), .vld_in_n(vld_in_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] n, logic [2:0] s);
        logic [31:0] k = (s == 0) ? 32'h0 : m_mask[s];
        return (n & ~k) | (o & k);
    endfunction

    task automatic drive(input logic [11:0] ins, input logic wn, input logic [31:0] d,
                         input logic vn, input logic al, input logic iv);
        @(negedge clk);
        instr = ins; wr_n = wn; bus_in = d; vld_in_n = vn; addr_ld = al; instr_vld = iv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(12'h0, 1'b1, 32'h0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic do_write(input logic [2:0] top, input logic [2:0] s, input logic [5:0] op,
                            input logic [31:0] d, input logic vn);
        drive({top, s, op}, 1'b0, d, vn, 1'b0, 1'b1);
        case (op)
            C_CFG:  m_cfg  = mrg(m_cfg, d, s);
            C_CMP:  m_cmp  = mrg(m_cmp, d, s);
            C_DSEL: m_dsel = mrg(m_dsel, d, s);
            C_MASK: if (s != 0) m_mask[s] = d;
            C_MOVE: begin m_mem[m_addr] = mrg(m_mem[m_addr], m_cmp, s); m_empty[m_addr] = vn; end
            default: ;
        endcase
    endtask

    task automatic do_fetch(input logic [2:0] s);
        drive({3'b000, s, C_MOVE}, 1'b1, 32'h0, 1'b1, 1'b0, 1'b1);
        m_cmp = mrg(m_cmp, m_mem[m_addr], s);
    endtask

    task automatic load_addr(input logic [7:0] a);
        drive(12'h0, 1'b1, {24'h0, a}, 1'b1, 1'b1, 1'b0);
        m_addr = a;
    endtask

    task automatic do_read(input logic [2:0] s, input logic [5:0] op, input string req);
        sb_item_t it;
        drive({3'b000, s, op}, 1'b1, 32'h0, 1'b1, 1'b0, 1'b1);
        it.due = cyc + 1;
        it.req = req;
        it.chk = 1;
        case (op)
            C_CFG:  it.val = m_cfg;
            C_CMP:  it.val = m_cmp;
            C_DSEL: it.val = m_dsel;
            C_STAT: it.val = {16'h0, m_addr, 7'h0, m_empty[m_addr]};
            C_MASK: begin it.val = m_mask[s]; it.chk = (s != 0); end
            default: it.val = 32'h0;
        endcase
        sb.push_back(it);
    endtask

    // Monitor: compare due reads, otherwise expect an undriven bus.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                cur = sb.pop_front();
                checks++;
                if (!bus_oe) begin
                    errors++;
                    $display("FAIL %s bus_oe actual 0 expected 1", cur.req);
                end else if (cur.chk && bus_out !== cur.val) begin
                    errors++;
                    $display("FAIL %s bus_out actual %h expected %h", cur.req, bus_out, cur.val);
                end
            end else begin
                checks++;
                if (bus_oe !== 1'b0) begin
                    errors++;
                    $display("FAIL R11/R10 bus_oe actual %b expected 0 at cycle %0d", bus_oe, cyc);
                end
            end
        end
    end

    initial begin
        m_cfg = 0; m_cmp = 0; m_dsel = 0; m_addr = 0; m_empty = '1;
        for (int i = 0; i < 8; i++) m_mask[i] = 0;
        for (int i = 0; i < 256; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        do_read(0, C_CFG,  "R1 cfg");
        do_read(0, C_CMP,  "R1 cmp");
        do_read(0, C_DSEL, "R1 dsel");
        do_read(5, C_MASK, "R1 mask5");
        do_read(0, C_STAT, "R1 status");
        // R3 unmasked writes
        do_write(0, 0, C_CFG,  32'hA5A5_1234, 1);
        do_write(0, 0, C_CMP,  32'hDEAD_BEEF, 1);
        do_write(0, 0, C_DSEL, 32'h0000_00F1, 1);
        do_read(0, C_CFG,  "R3 cfg");
        do_read(0, C_CMP,  "R3 cmp");
        do_read(0, C_DSEL, "R3 dsel");
        // R5 mask writes, selector 0 dropped
        do_write(0, 3, C_MASK, 32'hFFFF_0000, 1);
        do_write(0, 7, C_MASK, 32'h0F0F_0F0F, 1);
        do_write(0, 0, C_MASK, 32'h1234_5678, 1);
        for (int s = 1; s < 8; s++) do_read(s[2:0], C_MASK, "R5 mask");
        do_read(0, C_MASK, "R6 mask0 unchecked");
        // R4 masked writes
        do_write(0, 3, C_CMP,  32'h1111_2222, 1);
        do_write(0, 7, C_CFG,  32'hFFFF_FFFF, 1);
        do_write(0, 3, C_DSEL, 32'hABCD_EF01, 1);
        do_read(0, C_CMP,  "R4 cmp");
        do_read(0, C_CFG,  "R4 cfg");
        do_read(0, C_DSEL, "R4 dsel");
        // R2 top bits ignored
        do_write(3'b111, 0, C_DSEL, 32'h5555_AAAA, 1);
        do_write(3'b101, 0, C_CFG,  32'h0BAD_F00D, 1);
        do_read(0, C_DSEL, "R2 dsel");
        do_read(0, C_CFG,  "R2 cfg");
        // R9 address load, R7 move into store
        load_addr(8'h05);
        do_read(0, C_STAT, "R9 status addr");
        do_write(0, 0, C_CMP, 32'hCAFE_0001, 1);
        do_write(0, 0, C_MOVE, 32'h0, 0);
        do_read(0, C_STAT, "R7 status valid");
        load_addr(8'h09);
        do_write(0, 0, C_CMP, 32'h7777_8888, 1);
        do_write(0, 0, C_MOVE, 32'h0, 1);
        do_read(0, C_STAT, "R7 status empty");
        do_write(0, 0, C_CMP, 32'h0000_0000, 1);
        do_write(0, 3, C_MOVE, 32'h0, 0);
        do_read(0, C_STAT, "R7 masked store flag");
        // R8 fetch back masked and unmasked
        do_write(0, 0, C_CMP, 32'h1234_5678, 1);
        do_fetch(3);
        do_read(0, C_CMP, "R8 masked fetch");
        do_read(0, C_STAT, "R8 flag unchanged");
        load_addr(8'h05);
        do_fetch(0);
        do_read(0, C_CMP, "R8 unmasked fetch");
        do_read(0, C_STAT, "R8 status after fetch");
        // R10 undefined opcodes and status write
        do_write(0, 0, 6'b000000, 32'hFFFF_FFFF, 1);
        do_write(0, 0, 6'b111111, 32'hFFFF_FFFF, 1);
        do_write(0, 0, C_STAT, 32'hFFFF_FFFF, 1);
        drive({3'b000, 3'b000, 6'b010101}, 1'b1, 32'h0, 1'b1, 1'b0, 1'b1);
        do_read(0, C_CFG,  "R10 cfg");
        do_read(0, C_CMP,  "R10 cmp");
        do_read(0, C_DSEL, "R10 dsel");
        do_read(0, C_STAT, "R10 status");
        idle(4);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R6 pending reads actual %0d expected 0", sb.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule